// File: doc/BRIEF.md
# Inverter Trigger Pulse Generator with Soft Start

This block drives the two gate trigger lines of a medium-frequency inverter. It runs on a single reference clock and takes two digitized pulse trains from external voltage-controlled oscillators. The rate of the frequency train sets the switching rate. Each of its rising edges opens a new switching interval and hands the next trigger pulse to the other leg, so each leg toggles at half the train's rate. The duty train sets the pulse width. Its rising edges are counted over every interval, and a faster train gives a wider pulse. A 4-bit duty switch scales that count.

A second 4-bit switch sets how long the soft-start ramp takes. After the block is enabled, the largest width it allows climbs from zero to the full interval in sixteen equal steps. A width is always kept below one interval minus a fixed dead time, so the two legs can never conduct together. The start input enables the block. Overvoltage and overcurrent inputs stop both legs at once, and either one latches an alarm that only reset clears.

Top module: `inverter_trigger_pwm`

## Requirements
- R1: Each pulse input passes through a two-flop synchronizer, and only its low-to-high transitions count as events. An input held high produces no further events.
- R2: Each frequency event starts a new interval and makes the other leg active. After an enable, the first pulse appears on leg A. Over time both legs carry the same number of pulses, give or take one.
- R3: A trigger pulse rises DEAD_CLKS clocks after its interval opens. The two gate outputs are never high in the same cycle.
- R4: Pulse width in clocks is N × duty_sel_i × WIDTH_UNIT, where N counts the duty events in the interval that just closed (saturating at 2^DW−1). A duty_sel_i of 0 gives no pulse.
- R5: The width is clamped to L − DEAD_CLKS, where L is the length in clocks of the interval that just closed. The clamp is 0 when L ≤ DEAD_CLKS.
- R6: While enabled, a ramp level climbs from 0 to 16, one step every ramp_sel_i × STEP_CLKS clocks. The width is also limited to floor((L − DEAD_CLKS) × level / 16).
- R7: A ramp_sel_i of 0 takes the level to 16 one clock after enable.
- R8: When start_i is low, both gates are low one clock later, the ramp level goes back to 0, and the next enable starts again on leg A.
- R9: When ovp_i or ocp_i is high, both gates are low one clock later. The alarm is set one clock later and stays set until reset, and the gates stay low while it is set.
- R10: Under reset, both gates and the alarm are low. Reset is applied asynchronously and released after two clocks.
- R11: A frequency event that arrives before a pulse has finished cuts that pulse short on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_pulse_i | input | 1 | Frequency-setting pulse train (asynchronous) |
| duty_pulse_i | input | 1 | Duty-setting pulse train (asynchronous) |
| duty_sel_i | input | 4 | Duty scaling switch |
| ramp_sel_i | input | 4 | Soft-start duration switch |
| start_i | input | 1 | Enable; high once the regulator signal is above threshold |
| ovp_i | input | 1 | Overvoltage fault level |
| ocp_i | input | 1 | Overcurrent fault level |
| gate_a_o | output | 1 | Trigger pulse, leg A |
| gate_b_o | output | 1 | Trigger pulse, leg B |
| alarm_o | output | 1 | Latched fault alarm |

## Verification
The bench builds the block with CNT_W=12, DEAD_CLKS=3, WIDTH_UNIT=2 and STEP_CLKS=8. With these values the slowest ramp finishes in under two thousand clocks, so a complete soft start fits in a short run. A 200-clock interval also fits inside the counters, which lets short intervals of tens of clocks exercise both the clamp and the early-edge truncation. Interval lengths and duty-train periods are chosen to divide evenly, so the expected widths have exact closed-form values alongside the clock-by-clock model.

// File: rtl/invtrig_pkg.sv
package invtrig_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DEAD = 2'd1,
    PH_ON   = 2'd2
  } leg_phase_e;

  localparam int unsigned RAMP_STEPS = 16;
  localparam int unsigned LEVEL_W    = 5;

endpackage

// File: rtl/invtrig_edge_sync.sv
module invtrig_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

endmodule

// File: rtl/invtrig_interval_meter.sv
module invtrig_interval_meter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fe_i,
  input  logic             de_i,
  output logic [CNT_W-1:0] iv_len_o,
  output logic [DW-1:0]    dedges_o
);
  localparam logic [CNT_W-1:0] LEN_MAX = '1;
  localparam logic [DW-1:0]    DE_MAX  = '1;

  logic [CNT_W-1:0] len_q, len_d;
  logic [DW-1:0]    dcnt_q, dcnt_d;
  logic [DW-1:0]    dsum;

  always_comb begin
    dsum = (de_i && dcnt_q != DE_MAX) ? dcnt_q + 1'b1 : dcnt_q;
    if (fe_i) begin
      len_d  = {{(CNT_W-1){1'b0}}, 1'b1};
      dcnt_d = '0;
    end else begin
      len_d  = (len_q != LEN_MAX) ? len_q + 1'b1 : len_q;
      dcnt_d = dsum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      dcnt_q <= '0;
    end else begin
      len_q  <= len_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign iv_len_o = len_q;
  assign dedges_o = dsum;

endmodule

// File: rtl/invtrig_softstart.sv
module invtrig_softstart
  import invtrig_pkg::*;
#(
  parameter int unsigned STEP_CLKS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [3:0]         ramp_sel_i,
  output logic [LEVEL_W-1:0] level_o
);
  localparam int unsigned SW = $clog2(15 * STEP_CLKS + 1);
  localparam logic [LEVEL_W-1:0] LVL_FULL = LEVEL_W'(RAMP_STEPS);

  logic [SW-1:0]      scnt_q, scnt_d;
  logic [LEVEL_W-1:0] lvl_q, lvl_d;
  logic [SW-1:0]      step_len;

  always_comb begin
    step_len = SW'(ramp_sel_i) * SW'(STEP_CLKS);
    scnt_d   = scnt_q;
    lvl_d    = lvl_q;
    if (!run_i) begin
      scnt_d = '0;
      lvl_d  = '0;
    end else if (ramp_sel_i == 4'd0) begin
      scnt_d = '0;
      lvl_d  = LVL_FULL;
    end else if (scnt_q >= step_len - 1'b1) begin
      scnt_d = '0;
      if (lvl_q < LVL_FULL) lvl_d = lvl_q + 1'b1;
    end else begin
      scnt_d = scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      lvl_q  <= '0;
    end else begin
      scnt_q <= scnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign level_o = lvl_q;

  // R6
  ramp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_FULL);
  // R6
  ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> lvl_q >= $past(lvl_q));
  // R8
  ramp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> lvl_q == '0);

endmodule

// File: rtl/invtrig_gate_seq.sv
module invtrig_gate_seq
  import invtrig_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned DEAD_CLKS  = 4,
  parameter int unsigned WIDTH_UNIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               fe_i,
  input  logic [CNT_W-1:0]   iv_len_i,
  input  logic [DW-1:0]      dedges_i,
  input  logic [3:0]         duty_sel_i,
  input  logic [LEVEL_W-1:0] level_i,
  output logic               gate_a_o,
  output logic               gate_b_o
);
  localparam int unsigned XW   = CNT_W + DW + 8;
  localparam int unsigned DEFF = (DEAD_CLKS < 1) ? 1 : DEAD_CLKS;
  localparam logic [CNT_W-1:0] DEAD_V = CNT_W'(DEFF);
  localparam logic [CNT_W-1:0] ONE_V  = {{(CNT_W-1){1'b0}}, 1'b1};

  leg_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic [CNT_W-1:0] wlat_q, wlat_d;
  logic             leg_q, leg_d;

  logic [CNT_W-1:0] span;
  logic [XW-1:0]    cap, prod, wsel;

  always_comb begin
    span = (iv_len_i > DEAD_V) ? iv_len_i - DEAD_V : '0;
    cap  = (XW'(span) * XW'(level_i)) >> 4;
    prod = XW'(dedges_i) * XW'(duty_sel_i) * XW'(WIDTH_UNIT);
    wsel = (prod < cap) ? prod : cap;
  end

  always_comb begin
    ph_d   = ph_q;
    tcnt_d = tcnt_q;
    wlat_d = wlat_q;
    leg_d  = leg_q;
    if (!run_i) begin
      ph_d   = PH_IDLE;
      tcnt_d = '0;
      leg_d  = 1'b1;
    end else if (fe_i) begin
      ph_d   = PH_DEAD;
      tcnt_d = DEAD_V;
      leg_d  = ~leg_q;
      wlat_d = wsel[CNT_W-1:0];
    end else begin
      unique case (ph_q)
        PH_DEAD: begin
          if (tcnt_q == ONE_V) begin
            ph_d   = (wlat_q == '0) ? PH_IDLE : PH_ON;
            tcnt_d = wlat_q;
          end else begin
            tcnt_d = tcnt_q - 1'b1;
          end
        end
        PH_ON: begin
          if (tcnt_q == ONE_V) begin
            ph_d   = PH_IDLE;
            tcnt_d = '0;
          end else begin
            tcnt_d = tcnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      tcnt_q <= '0;
      wlat_q <= '0;
      leg_q  <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      tcnt_q <= tcnt_d;
      wlat_q <= wlat_d;
      leg_q  <= leg_d;
    end
  end

  assign gate_a_o = (ph_q == PH_ON) & ~leg_q;
  assign gate_b_o = (ph_q == PH_ON) &  leg_q;

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a_o && gate_b_o));
  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !gate_a_o && !gate_b_o);
  // R11
  edge_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_i |=> !gate_a_o && !gate_b_o);

endmodule

// File: rtl/inverter_trigger_pwm.sv
module inverter_trigger_pwm
  import invtrig_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned DEAD_CLKS  = 4,
  parameter int unsigned WIDTH_UNIT = 4,
  parameter int unsigned STEP_CLKS  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freq_pulse_i,
  input  logic       duty_pulse_i,
  input  logic [3:0] duty_sel_i,
  input  logic [3:0] ramp_sel_i,
  input  logic       start_i,
  input  logic       ovp_i,
  input  logic       ocp_i,
  output logic       gate_a_o,
  output logic       gate_b_o,
  output logic       alarm_o
);
  localparam int unsigned NPULSE = 2;

  logic [1:0]          rs_q;
  logic                srst_n;
  logic [NPULSE-1:0]   pulse_in, pulse_rise;
  logic                alarm_q, alarm_d;
  logic                fault, run;
  logic [CNT_W-1:0]    iv_len;
  logic [DW-1:0]       dedges;
  logic [LEVEL_W-1:0]  level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign pulse_in = {duty_pulse_i, freq_pulse_i};

  for (genvar gi = 0; gi < NPULSE; gi++) begin : g_sync
    invtrig_edge_sync u_sync (
      .clk    (clk),
      .rst_n  (srst_n),
      .async_i(pulse_in[gi]),
      .rise_o (pulse_rise[gi])
    );
  end

  always_comb begin
    fault   = ovp_i | ocp_i;
    run     = start_i & ~fault & ~alarm_q;
    alarm_d = alarm_q | fault;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) alarm_q <= 1'b0;
    else         alarm_q <= alarm_d;
  end

  invtrig_interval_meter #(.CNT_W(CNT_W), .DW(DW)) u_meter (
    .clk     (clk),
    .rst_n   (srst_n),
    .fe_i    (pulse_rise[0]),
    .de_i    (pulse_rise[1]),
    .iv_len_o(iv_len),
    .dedges_o(dedges)
  );

  invtrig_softstart #(.STEP_CLKS(STEP_CLKS)) u_ramp (
    .clk       (clk),
    .rst_n     (srst_n),
    .run_i     (run),
    .ramp_sel_i(ramp_sel_i),
    .level_o   (level)
  );

  invtrig_gate_seq #(
    .CNT_W(CNT_W), .DW(DW), .DEAD_CLKS(DEAD_CLKS), .WIDTH_UNIT(WIDTH_UNIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .run_i     (run),
    .fe_i      (pulse_rise[0]),
    .iv_len_i  (iv_len),
    .dedges_i  (dedges),
    .duty_sel_i(duty_sel_i),
    .level_i   (level),
    .gate_a_o  (gate_a_o),
    .gate_b_o  (gate_b_o)
  );

  assign alarm_o = alarm_q;

  // R9
  alarm_set_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ovp_i || ocp_i) |=> alarm_o && !gate_a_o && !gate_b_o);
  // R9
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    alarm_o |=> alarm_o);
  // R9
  alarm_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    alarm_o |-> !gate_a_o && !gate_b_o);

endmodule

// File: tb/tb_inverter_trigger_pwm.sv
`timescale 1ns/1ps
module tb_inverter_trigger_pwm;
  localparam int CNT_W = 12, DW = 8, DEAD = 3, UNIT = 2, STEP = 8;
  localparam int PMAX = (1 << CNT_W) - 1, DMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic freq_in = 1'b0, duty_in = 1'b0;
  logic [3:0] dsel = 4'd0, rsel = 4'd0;
  logic start = 1'b0, ovp = 1'b0, ocp = 1'b0;
  logic ga, gb, alarm;

  inverter_trigger_pwm #(.CNT_W(CNT_W), .DW(DW), .DEAD_CLKS(DEAD),
    .WIDTH_UNIT(UNIT), .STEP_CLKS(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .freq_pulse_i(freq_in), .duty_pulse_i(duty_in),
    .duty_sel_i(dsel), .ramp_sel_i(rsel), .start_i(start), .ovp_i(ovp),
    .ocp_i(ocp), .gate_a_o(ga), .gate_b_o(gb), .alarm_o(alarm));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R10";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // pulse generators
  int f_per = 200, d_per = 20, f_hold = -1, fc = 0, dc = 0;
  initial forever begin
    @(negedge clk);
    if (f_hold >= 0) freq_in = f_hold[0];
    else begin fc = (fc + 1) % f_per; freq_in = (fc < f_per / 2); end
    dc = (dc + 1) % d_per; duty_in = (dc < d_per / 2);
  end

  // behavioural reference model
  int m_rc, m_f[3], m_d[3], m_pc, m_dc, m_ph, m_tc, m_wl, m_leg, m_lvl, m_sc, m_al;
  bit exp_a, exp_b, exp_al;

  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

  task automatic m_reset();
    foreach (m_f[i]) begin m_f[i] = 0; m_d[i] = 0; end
    m_pc = 0; m_dc = 0; m_ph = 0; m_tc = 0; m_wl = 0; m_leg = 1;
    m_lvl = 0; m_sc = 0; m_al = 0;
  endtask

  task automatic m_step();
    bit fe, de, flt, run;
    int span, cap, prod;
    fe = m_f[1] && !m_f[2];
    de = m_d[1] && !m_d[2];
    m_f[2] = m_f[1]; m_f[1] = m_f[0]; m_f[0] = freq_in;
    m_d[2] = m_d[1]; m_d[1] = m_d[0]; m_d[0] = duty_in;
    flt = ovp || ocp;
    run = start && !flt && !m_al;
    if (!run) begin m_ph = 0; m_tc = 0; m_leg = 1; end
    else if (fe) begin
      span = (m_pc > DEAD) ? m_pc - DEAD : 0;
      cap  = (span * m_lvl) / 16;
      prod = imin(m_dc + de, DMAX) * int'(dsel) * UNIT;
      m_wl = imin(prod, cap); m_ph = 1; m_tc = DEAD; m_leg = 1 - m_leg;
    end else if (m_ph == 1) begin
      if (m_tc == 1) begin m_ph = (m_wl == 0) ? 0 : 2; m_tc = m_wl; end
      else m_tc--;
    end else if (m_ph == 2) begin
      if (m_tc == 1) begin m_ph = 0; m_tc = 0; end else m_tc--;
    end
    if (fe) begin m_pc = 1; m_dc = 0; end
    else begin m_pc = imin(m_pc + 1, PMAX); m_dc = imin(m_dc + de, DMAX); end
    if (!run) begin m_lvl = 0; m_sc = 0; end
    else if (rsel == 0) begin m_lvl = 16; m_sc = 0; end
    else if (m_sc >= int'(rsel) * STEP - 1) begin
      m_sc = 0; if (m_lvl < 16) m_lvl++;
    end else m_sc++;
    m_al = m_al | flt;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_reset(); m_rc = 0; end
    else if (m_rc < 2) begin m_rc++; m_reset(); end
    else m_step();
    exp_a = (m_ph == 2) && (m_leg == 0);
    exp_b = (m_ph == 2) && (m_leg == 1);
    exp_al = m_al[0];
  end

  // per-clock comparison and pulse monitors
  int wa = 0, last_wa = 0, na = 0, nb = 0, hi_cnt = 0, first_leg = 0;
  logic pa = 1'b0, pb = 1'b0;
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk({cur_req, " gate_a"}, ga, exp_a);
      chk({cur_req, " gate_b"}, gb, exp_b);
      chk({cur_req, " alarm"}, alarm, exp_al);
      if (ga && gb) chk("R3 overlap", 1, 0);
      if (ga) wa++; else if (wa > 0) begin last_wa = wa; wa = 0; end
      if (ga && !pa) begin na++; if (first_leg == 0) first_leg = 1; end
      if (gb && !pb) begin nb++; if (first_leg == 0) first_leg = 2; end
      if (ga || gb) hi_cnt++;
      pa = ga; pb = gb;
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cur_req = "R10";
    cyc(5);
    chk("R10 gate_a in reset", ga, 0);
    chk("R10 alarm in reset", alarm, 0);
    rst_n = 1'b1; cyc(5);

    // R7 + R4 + R2: immediate full width, 10 duty events x 5 x 2 = 100
    cur_req = "R4"; dsel = 4'd5; rsel = 4'd0; na = 0; nb = 0; first_leg = 0;
    start = 1'b1; cyc(2000);
    chk("R4 width", last_wa, 100);
    chk("R7 full at once", (last_wa == 100) ? 1 : 0, 1);
    chk("R2 first leg A", first_leg, 1);
    chk("R2 balance", ((na - nb) <= 1 && (nb - na) <= 1 && na >= 5) ? 1 : 0, 1);

    // R5: 20 events x 15 x 2 = 600 clamped to 200 - 3
    cur_req = "R5"; dsel = 4'd15; d_per = 10; cyc(2000);
    chk("R5 clamp", last_wa, 197);

    // R8 then R6: stop, slow ramp restart
    cur_req = "R8"; start = 1'b0; cyc(3);
    chk("R8 gates off", ga | gb, 0);
    cyc(20);
    cur_req = "R6"; rsel = 4'd15; last_wa = 0; start = 1'b1; cyc(450);
    chk("R6 early narrow", (last_wa > 0 && last_wa < 100) ? 1 : 0, 1);
    cyc(2400);
    chk("R6 ramp end", last_wa, 197);

    // R11: short and changing intervals, edges cut pulses
    cur_req = "R11"; rsel = 4'd1; dsel = 4'd9; d_per = 7; f_per = 60; cyc(800);
    f_per = 300; cyc(700); f_per = 40; cyc(600);

    // R4: zero duty switch gives no pulse
    cur_req = "R4"; dsel = 4'd0; f_per = 200; d_per = 20; cyc(500);
    hi_cnt = 0; cyc(600);
    chk("R4 zero duty", hi_cnt, 0);

    // R1: frequency input held high yields no further events
    cur_req = "R1"; dsel = 4'd5; cyc(600); f_hold = 1; cyc(300);
    hi_cnt = 0; cyc(500);
    chk("R1 held high", hi_cnt, 0);
    f_hold = -1; cyc(600);

    // R8: drop start in the middle of operation
    cur_req = "R8"; cyc(37); start = 1'b0; cyc(1);
    chk("R8 stop next clock", ga | gb, 0);
    cyc(50); start = 1'b1; cyc(800);

    // R9: overvoltage pulse latches alarm
    cur_req = "R9"; cyc(23); ovp = 1'b1; cyc(1); ovp = 1'b0;
    chk("R9 alarm set", alarm, 1);
    chk("R9 gates off", ga | gb, 0);
    hi_cnt = 0; cyc(600);
    chk("R9 stays quiet", hi_cnt, 0);
    chk("R9 alarm held", alarm, 1);

    // R10: reset clears alarm, then overcurrent
    cur_req = "R10"; rst_n = 1'b0; cyc(3);
    chk("R10 alarm cleared", alarm, 0);
    rst_n = 1'b1; cyc(800);
    cur_req = "R9"; ocp = 1'b1; cyc(1); ocp = 1'b0;
    chk("R9 ocp alarm", alarm, 1);
    cyc(300);
    finish_run();
  end

endmodule